// File: doc/BRIEF.md
# Synchronous Burst SRAM with Address Sequencer

This block is a single-clock static RAM holding 18-bit words. Each word has sixteen data bits and two parity bits, split into a high half and a low half. Every half has its own write enable, and each parity bit travels with the data byte of its own half. An access begins when an address is captured through one of two address strobes: a processor-side strobe and a controller-side strobe. A 2-bit burst counter then walks the low two address bits through a group of four aligned words. Each step of the counter is requested with an advance input. A parameter selects linear or interleaved burst order.

All control inputs are sampled on the rising clock edge. Read data comes from a registered output stage one edge after the access. The output-enable input gates the drivers combinationally, with no clock involved. The bidirectional bus appears as separate input data, output data and per-half drive-enable ports. A pad ring would turn these into tri-state pins. The depth is set by the address width parameter. A 16-bit address gives 64K words. The default is a smaller array.

Top module: `burst_sram`

## Requirements
- R1: While reset is high and after it is released, the device is deselected and the burst counter is zero. Both drive enables (`dout_en`, bit 1 = high half, bit 0 = low half) are low, and the output data and parity registers read zero.
- R2: At a rising edge with `cs_n` low and either `ads_proc_n` or `ads_ctrl_n` low, `addr` is loaded into the address register. The burst counter clears and the device becomes selected. The loaded word is accessed at the next edge.
- R3: At an edge with `cs_n` high and `ads_ctrl_n` low, the device becomes deselected. While deselected it drives neither half and ignores write enables. This holds until a new address is loaded.
- R4: With `cs_n` high, a low `ads_proc_n` is ignored. It loads no address, keeps the selection state, and does not block advance.
- R5: A low `adv_n` at an edge steps the 2-bit burst counter by one, modulo 4. It is ignored at any edge where R2 loads an address. With `adv_n` high the counter holds.
- R6: In linear order the low two bits of the accessed address equal (loaded low bits + counter) mod 4. The upper address bits stay at the loaded value.
- R7: In interleaved order the low two bits of the accessed address equal the loaded low bits XOR the counter. The upper bits stay at the loaded value.
- R8: The high half is data bits 15..8 plus parity bit 1. The low half is data bits 7..0 plus parity bit 0. A write with only one half's enable low changes only that half of the stored word.
- R9: When a half's write enable (`we_hi_n` / `we_lo_n`) is sampled low, that half's drive enable is low until the next edge.
- R10: Output data registered at an edge holds the word at the address accessed at that edge. In a half that is written at the same edge, it holds the newly written value.
- R11: `dout_en` is the AND of a low `oe_n` and the per-half drive state registered at the last edge. It follows `oe_n` combinationally, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all control and data inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| ads_proc_n | input | 1 | Active-low processor-side address strobe |
| ads_ctrl_n | input | 1 | Active-low controller-side address strobe |
| adv_n | input | 1 | Active-low burst advance |
| addr | input | ADDR_W | Word address captured on a strobe |
| we_hi_n | input | 1 | Active-low write enable, high half |
| we_lo_n | input | 1 | Active-low write enable, low half |
| oe_n | input | 1 | Active-low asynchronous output enable |
| din_data | input | 2*HALF_DATA_W | Write data, high byte in the upper bits |
| din_par | input | 2*HALF_PAR_W | Write parity, bit 1 with the high half |
| dout_data | output | 2*HALF_DATA_W | Registered read data |
| dout_par | output | 2*HALF_PAR_W | Registered read parity |
| dout_en | output | 2 | Drive enable per half (bit 1 high, bit 0 low) |

## Verification
The bench builds the block twice with a 6-bit address (64 words). One instance uses linear order and the other interleaved order, and both receive identical stimulus. The small depth lets every word be written and tracked by the reference model. Because both orders see the same burst from an unaligned start offset, a swapped or mis-wrapped sequence shows up as a data mismatch in one instance. Each instance has its own model copy, so the two orders are checked on every clock. The model covers the strobe priority cases, wrap-around past four advances, half writes and write-through reads.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;

  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;

  // Low two address bits for a given start offset and burst count.
  function automatic logic [1:0] burst_offset(input burst_order_e ord,
                                              input logic [1:0] start,
                                              input logic [1:0] step);
    logic [1:0] r;
    if (ord == ORDER_INTERLEAVED) r = start ^ step;
    else                          r = start + step;
    return r;
  endfunction

endpackage

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
module burst_addr_seq
  import burst_sram_pkg::*;
#(
  parameter int           ADDR_W = 10,
  parameter burst_order_e ORDER  = ORDER_LINEAR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ads_proc_n,
  input  logic              ads_ctrl_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              selected,
  output logic [1:0]        count
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              sel_q;
  logic              load;
  logic              desel;

  // A strobe only counts together with chip select; the controller
  // strobe alone (chip select high) deselects.
  assign load  = !cs_n && (!ads_proc_n || !ads_ctrl_n);
  assign desel = cs_n && !ads_ctrl_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
    end else if (load) begin
      base_q <= addr;
      cnt_q  <= '0;
      sel_q  <= 1'b1;
    end else begin
      if (desel)  sel_q <= 1'b0;
      if (!adv_n) cnt_q <= cnt_q + 2'd1;
    end
  end

  assign cur_addr = {base_q[ADDR_W-1:2], burst_offset(ORDER, base_q[1:0], cnt_q)};
  assign selected = sel_q;
  assign count    = cnt_q;

endmodule

// File: rtl/sram_lane.sv
`timescale 1ns/1ps
module sram_lane #(
  parameter int ADDR_W = 10,
  parameter int W      = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              drive
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];
  logic         wr;

  assign wr = sel && !we_n;

  // Storage kept free of reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr) mem[addr] <= wdata;
  end

  // Write-first output register plus per-half drive state.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      drive <= 1'b0;
    end else begin
      rdata <= wr ? wdata : mem[addr];
      drive <= sel && we_n;
    end
  end

endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int           ADDR_W      = 10,
  parameter int           HALF_DATA_W = 8,
  parameter int           HALF_PAR_W  = 1,
  parameter burst_order_e ORDER       = ORDER_LINEAR
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs_n,
  input  logic                     ads_proc_n,
  input  logic                     ads_ctrl_n,
  input  logic                     adv_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     we_hi_n,
  input  logic                     we_lo_n,
  input  logic                     oe_n,
  input  logic [2*HALF_DATA_W-1:0] din_data,
  input  logic [2*HALF_PAR_W-1:0]  din_par,
  output logic [2*HALF_DATA_W-1:0] dout_data,
  output logic [2*HALF_PAR_W-1:0]  dout_par,
  output logic [1:0]               dout_en
);

  localparam int HALF_W = HALF_DATA_W + HALF_PAR_W;
  localparam int NHALF  = 2;

  logic [ADDR_W-1:0] cur_addr;
  logic              selected;
  logic [1:0]        burst_cnt;
  logic [NHALF-1:0]  we_n_vec;
  logic [NHALF-1:0]  drive_vec;

  assign we_n_vec = {we_hi_n, we_lo_n};

  burst_addr_seq #(
    .ADDR_W (ADDR_W),
    .ORDER  (ORDER)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .adv_n      (adv_n),
    .addr       (addr),
    .cur_addr   (cur_addr),
    .selected   (selected),
    .count      (burst_cnt)
  );

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [HALF_W-1:0] wdata;
    logic [HALF_W-1:0] rdata;

    assign wdata = {din_par[h*HALF_PAR_W +: HALF_PAR_W],
                    din_data[h*HALF_DATA_W +: HALF_DATA_W]};

    sram_lane #(
      .ADDR_W (ADDR_W),
      .W      (HALF_W)
    ) u_lane (
      .clk   (clk),
      .rst   (rst),
      .sel   (selected),
      .we_n  (we_n_vec[h]),
      .addr  (cur_addr),
      .wdata (wdata),
      .rdata (rdata),
      .drive (drive_vec[h])
    );

    assign dout_data[h*HALF_DATA_W +: HALF_DATA_W] = rdata[HALF_DATA_W-1:0];
    assign dout_par[h*HALF_PAR_W +: HALF_PAR_W]    = rdata[HALF_W-1:HALF_DATA_W];
    assign dout_en[h] = !oe_n && drive_vec[h];
  end

endmodule

// File: rtl/burst_sram_chk.sv
`timescale 1ns/1ps
module burst_sram_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       ads_proc_n,
  input logic       ads_ctrl_n,
  input logic       adv_n,
  input logic       we_hi_n,
  input logic       we_lo_n,
  input logic       oe_n,
  input logic [1:0] dout_en,
  input logic       selected,
  input logic [1:0] burst_cnt
);

  logic strobe_load;
  assign strobe_load = !cs_n && (!ads_proc_n || !ads_ctrl_n);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (dout_en == 2'b00) && !selected && (burst_cnt == 2'd0));

  assert_load_restarts_R2: assert property (@(posedge clk) disable iff (rst)
    strobe_load |=> selected && (burst_cnt == 2'd0));

  assert_deselect_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !ads_ctrl_n) |=> !selected ##1 (dout_en == 2'b00));

  assert_proc_strobe_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !ads_proc_n && ads_ctrl_n) |=> (selected == $past(selected)));

  assert_advance_steps_R5: assert property (@(posedge clk) disable iff (rst)
    (!adv_n && !strobe_load) |=> (burst_cnt == 2'($past(burst_cnt) + 2'd1)));

  assert_counter_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (adv_n && !strobe_load) |=> $stable(burst_cnt));

  assert_write_hi_undriven_R9: assert property (@(posedge clk) disable iff (rst)
    !we_hi_n |=> !dout_en[1]);

  assert_write_lo_undriven_R9: assert property (@(posedge clk) disable iff (rst)
    !we_lo_n |=> !dout_en[0]);

  assert_oe_gates_R11: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (dout_en == 2'b00));

endmodule

bind burst_sram burst_sram_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .ads_proc_n (ads_proc_n),
  .ads_ctrl_n (ads_ctrl_n),
  .adv_n      (adv_n),
  .we_hi_n    (we_hi_n),
  .we_lo_n    (we_lo_n),
  .oe_n       (oe_n),
  .dout_en    (dout_en),
  .selected   (selected),
  .burst_cnt  (burst_cnt)
);

// File: tb/burst_sram_test.sv
`timescale 1ns/1ps
module burst_sram_test;
  import burst_sram_pkg::*;

  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1;
  logic we_hi_n = 1'b1, we_lo_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   din_data = '0;
  logic [1:0]    din_par = '0;

  logic [15:0] dd [2];
  logic [1:0]  dp [2];
  logic [1:0]  de [2];

  always #2.5 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .ORDER(ORDER_LINEAR)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n),
    .adv_n(adv_n), .addr(addr), .we_hi_n(we_hi_n), .we_lo_n(we_lo_n), .oe_n(oe_n),
    .din_data(din_data), .din_par(din_par),
    .dout_data(dd[0]), .dout_par(dp[0]), .dout_en(de[0]));

  burst_sram #(.ADDR_W(AW), .ORDER(ORDER_INTERLEAVED)) uut_il (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n),
    .adv_n(adv_n), .addr(addr), .we_hi_n(we_hi_n), .we_lo_n(we_lo_n), .oe_n(oe_n),
    .din_data(din_data), .din_par(din_par),
    .dout_data(dd[1]), .dout_par(dp[1]), .dout_en(de[1]));

  // Reference model state, one copy per burst order (0 linear, 1 interleaved)
  int          m_base [2];
  int          m_cnt  [2];
  bit          m_sel  [2];
  bit          m_vh [2], m_vl [2];
  int          m_qh [2], m_ql [2];
  bit          m_kh [2], m_kl [2];
  int          mem_h [2][NW];
  int          mem_l [2][NW];
  bit          kn_h  [2][NW];
  bit          kn_l  [2][NW];

  int    checks = 0;
  int    fails  = 0;
  int    cycles = 0;
  string cur_req = "R1";

  task automatic model_step(input int k);
    int cur, off, wv;
    off = (k == 1) ? ((m_base[k] & 3) ^ m_cnt[k]) : (((m_base[k] & 3) + m_cnt[k]) & 3);
    cur = (m_base[k] & ~3) | off;
    if (rst) begin
      m_sel[k] = 0; m_cnt[k] = 0; m_base[k] = 0;
      m_vh[k] = 0; m_vl[k] = 0;
      m_qh[k] = 0; m_ql[k] = 0; m_kh[k] = 1; m_kl[k] = 1;
    end else begin
      if (m_sel[k] && !we_hi_n) begin
        wv = {din_par[1], din_data[15:8]};
        mem_h[k][cur] = wv; kn_h[k][cur] = 1;
        m_qh[k] = wv; m_kh[k] = 1;
      end else begin
        m_qh[k] = mem_h[k][cur]; m_kh[k] = kn_h[k][cur];
      end
      if (m_sel[k] && !we_lo_n) begin
        wv = {din_par[0], din_data[7:0]};
        mem_l[k][cur] = wv; kn_l[k][cur] = 1;
        m_ql[k] = wv; m_kl[k] = 1;
      end else begin
        m_ql[k] = mem_l[k][cur]; m_kl[k] = kn_l[k][cur];
      end
      m_vh[k] = m_sel[k] && we_hi_n;
      m_vl[k] = m_sel[k] && we_lo_n;
      if (!cs_n && (!ads_proc_n || !ads_ctrl_n)) begin
        m_base[k] = int'(addr); m_cnt[k] = 0; m_sel[k] = 1;
      end else begin
        if (cs_n && !ads_ctrl_n) m_sel[k] = 0;
        if (!adv_n) m_cnt[k] = (m_cnt[k] + 1) & 3;
      end
    end
  endtask

  always @(posedge clk) begin
    model_step(0);
    model_step(1);
    cycles++;
  end

  task automatic check_val(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic check_all();
    for (int k = 0; k < 2; k++) begin
      check_val(k ? "il dout_en" : "lin dout_en", int'(de[k]),
                int'({!oe_n && m_vh[k], !oe_n && m_vl[k]}));
      if (m_kh[k]) check_val(k ? "il high half" : "lin high half",
                             int'({dp[k][1], dd[k][15:8]}), m_qh[k]);
      if (m_kl[k]) check_val(k ? "il low half" : "lin low half",
                             int'({dp[k][0], dd[k][7:0]}), m_ql[k]);
    end
  endtask

  // One clock cycle: drive away from the edge, then compare.
  task automatic cyc(input bit c, input bit ap, input bit ac, input bit av,
                     input bit wh, input bit wl, input bit o,
                     input int a, input int d, input int p);
    @(negedge clk);
    cs_n = c; ads_proc_n = ap; ads_ctrl_n = ac; adv_n = av;
    we_hi_n = wh; we_lo_n = wl; oe_n = o;
    addr = AW'(a); din_data = 16'(d); din_par = 2'(p);
    #1;
    check_all();
  endtask

  task automatic idle(input bit o);
    cyc(0, 1, 1, 1, 1, 1, o, 0, 0, 0);
  endtask

  always @(posedge clk) begin
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    rst = 1'b1;
    cyc(1, 1, 1, 1, 1, 1, 0, 0, 0, 0);
    cyc(1, 1, 1, 1, 1, 1, 0, 0, 0, 0);
    @(negedge clk); rst = 1'b0;
    cyc(1, 1, 1, 1, 1, 1, 0, 0, 0, 0);

    // R2 / R8: fill words 0..15 with bursts, alternating strobes
    for (int g = 0; g < 4; g++) begin
      cur_req = "R2";
      if (g % 2 == 0) cyc(0, 0, 1, 1, 1, 1, 1, g * 4, 0, 0);
      else            cyc(0, 1, 0, 1, 1, 1, 1, g * 4, 0, 0);
      cur_req = "R8";
      for (int i = 0; i < 4; i++)
        cyc(0, 1, 1, 0, 0, 0, 1, 0, 16'hA000 + g * 16'h0111 + i * 16'h1357, i);
    end

    // R6 / R7: read burst from unaligned start 6, wrapping past four steps
    cur_req = "R6";
    cyc(0, 0, 1, 1, 1, 1, 0, 6, 0, 0);
    cur_req = "R7";
    for (int i = 0; i < 6; i++) cyc(0, 1, 1, 0, 1, 1, 0, 0, 0, 0);

    // R5: advance together with a load is ignored; later advance steps
    cur_req = "R5";
    cyc(0, 1, 0, 0, 1, 1, 0, 9, 0, 0);
    idle(0); idle(0);
    cyc(0, 1, 1, 0, 1, 1, 0, 0, 0, 0);
    idle(0); idle(0);

    // R4: chip select high with processor strobe: no load, advance still steps
    cur_req = "R4";
    cyc(1, 0, 1, 0, 1, 1, 0, 33, 0, 0);
    idle(0); idle(0);
    cyc(1, 0, 1, 1, 1, 1, 0, 40, 0, 0);
    idle(0); idle(0);

    // R8 / R9 / R10: high-half-only write at word 13 with outputs enabled
    cur_req = "R9";
    cyc(0, 0, 1, 1, 1, 1, 0, 13, 0, 0);
    cyc(0, 1, 1, 1, 0, 1, 0, 0, 16'h5AA5, 2'b10);
    cur_req = "R10";
    idle(0);
    cur_req = "R8";
    cyc(0, 1, 1, 1, 1, 0, 0, 0, 16'hC33C, 2'b01);
    idle(0); idle(0);

    // R10: write-through inside a read burst
    cur_req = "R10";
    cyc(0, 0, 1, 1, 1, 1, 0, 2, 0, 0);
    cyc(0, 1, 1, 0, 0, 0, 0, 0, 16'h1E2D, 2'b11);
    cyc(0, 1, 1, 0, 1, 1, 0, 0, 0, 0);
    idle(0);

    // R11: output enable toggled with no access change
    cur_req = "R11";
    cyc(0, 1, 1, 1, 1, 1, 1, 0, 0, 0);
    cyc(0, 1, 1, 1, 1, 1, 0, 0, 0, 0);
    cyc(0, 1, 1, 1, 1, 1, 1, 0, 0, 0);
    @(negedge clk); #1; oe_n = 1'b0; #0.5;
    check_all();

    // R3: deselect, attempted write while deselected, reload and verify
    cur_req = "R3";
    cyc(1, 1, 0, 1, 1, 1, 0, 0, 0, 0);
    cyc(1, 1, 1, 1, 1, 1, 0, 0, 0, 0);
    cyc(1, 1, 1, 1, 0, 0, 0, 0, 16'hFFFF, 2'b11);
    cyc(1, 1, 1, 0, 1, 1, 0, 0, 0, 0);
    cyc(0, 0, 1, 1, 1, 1, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0, 1, 1, 0, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule